// File: doc/BRIEF.md
# Three-Phase Gate Drive Output Conditioner

This block sits between a three-phase PWM timing unit and the inverter gate drivers. It receives one high-side and one low-side switching signal per phase. It passes each pair through four stages, always in the same order. The first stage is an optional per-phase swap of the two signals, used for brushless DC commutation. The second is a per-pin enable mask. The third is an optional high-frequency chopping carrier, used to drive pulse transformers; it can be switched on separately for the high-side pins and for the low-side pins. The last stage is a polarity stage that makes the pins active-high or active-low.

The chopping carrier comes from a free-running 8-bit prescaler whose limit is set by an input. A forced-off input overrides every stage and drives all six pins to their inactive level. This path is combinational, so an external shutdown reaches the pins without waiting for a clock edge. All data paths are combinational; the only state is the carrier prescaler.

Top module: `pwm_gate_drive`

## Requirements
- R1: When `xover_i[p]` is 1, phase p's high-side pin carries the raw low-side signal and its low-side pin carries the raw high-side signal. When `xover_i[p]` is 0, both signals pass straight through.
- R2: `out_en_i[2p]` enables the high-side pin of phase p and `out_en_i[2p+1]` enables its low-side pin. The enable is applied after crossover. A disabled pin sits at the inactive level.
- R3: With `chop_hi_en_i` = 1, each high-side pin is active only while both its masked signal and the carrier are high.
- R4: `chop_lo_en_i` chops the low-side pins in the same way, independently of `chop_hi_en_i`. The pins of a group whose chop enable is 0 are not chopped.
- R5: The carrier is low and the prescaler count is zero while `rst_ni` is low. After reset, the carrier toggles every `chop_div_i`+1 clock cycles. With a constant limit D, the carrier after n rising edges equals bit 0 of n/(D+1).
- R6: With `active_low_i` = 0 an active pin is driven 1 and an inactive pin 0. With `active_low_i` = 1 every pin is inverted, so the inactive level is 1.
- R7: While `force_off_i` is 1, all six pins sit at the inactive level for the selected polarity, whatever the other inputs and the carrier are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the carrier prescaler |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raw_hi_i | input | 3 | High-side signals from the timer, bit p = phase p |
| raw_lo_i | input | 3 | Low-side signals from the timer, bit p = phase p |
| xover_i | input | 3 | Per-phase crossover select |
| out_en_i | input | 6 | Pin enables, bit 2p = high of phase p, bit 2p+1 = low |
| chop_div_i | input | 8 | Carrier prescaler limit |
| chop_hi_en_i | input | 1 | Chop the high-side group |
| chop_lo_en_i | input | 1 | Chop the low-side group |
| active_low_i | input | 1 | Output polarity select, 1 = active-low |
| force_off_i | input | 1 | Drive every pin inactive |
| gate_hi_o | output | 3 | High-side gate pins, bit p = phase p |
| gate_lo_o | output | 3 | Low-side gate pins, bit p = phase p |

## Verification
The carrier assertions compare each cycle with the one before, so they take the prescaler limit as steady over at least one edge. The stimulus changes `chop_div_i` only while reset is held. The pass-through assertion only covers cycles in which no chop enable, crossover or inversion is active; the pin sweeps drive those controls at the falling clock edge, so every rising edge samples a settled input set.

// File: rtl/pwm_gd_pkg.sv
package pwm_gd_pkg;
  localparam int unsigned PIN_HI = 0;
  localparam int unsigned PIN_LO = 1;

  typedef enum logic {
    POL_ACT_HIGH = 1'b0,
    POL_ACT_LOW  = 1'b1
  } pol_e;

  function automatic logic drive_level(logic active, pol_e pol);
    return active ^ (pol == POL_ACT_LOW);
  endfunction
endpackage

// File: rtl/pwm_steer.sv
module pwm_steer #(
  parameter int unsigned N_PH = 3
) (
  input  logic [N_PH-1:0]   raw_hi_i,
  input  logic [N_PH-1:0]   raw_lo_i,
  input  logic [N_PH-1:0]   xover_i,
  input  logic [2*N_PH-1:0] out_en_i,
  output logic [N_PH-1:0]   sig_hi_o,
  output logic [N_PH-1:0]   sig_lo_o
);
  import pwm_gd_pkg::*;

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    logic hi_sel, lo_sel;
    // swap first, then mask per destination pin
    assign hi_sel      = xover_i[p] ? raw_lo_i[p] : raw_hi_i[p];
    assign lo_sel      = xover_i[p] ? raw_hi_i[p] : raw_lo_i[p];
    assign sig_hi_o[p] = hi_sel & out_en_i[2*p+PIN_HI];
    assign sig_lo_o[p] = lo_sel & out_en_i[2*p+PIN_LO];
  end
endmodule

// File: rtl/pwm_chop_carrier.sv
module pwm_chop_carrier #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             carrier_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             car_q;
  logic             wrap;

  // >= keeps the counter bounded if the limit is lowered mid-count
  assign wrap = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      car_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      car_q <= ~car_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign carrier_o = car_q;

  AST_CAR_HOLD:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (cnt_q < div_i) |=> (car_q == $past(car_q)));   // R5
  AST_CAR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (cnt_q >= div_i) |=> (car_q != $past(car_q)));  // R5
  AST_CNT_WRAP:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (cnt_q >= div_i) |=> (cnt_q == '0));            // R5
endmodule

// File: rtl/pwm_gate_stage.sv
module pwm_gate_stage #(
  parameter int unsigned N_PH = 3
) (
  input  logic [N_PH-1:0] sig_hi_i,
  input  logic [N_PH-1:0] sig_lo_i,
  input  logic            carrier_i,
  input  logic            chop_hi_en_i,
  input  logic            chop_lo_en_i,
  input  logic            active_low_i,
  input  logic            force_off_i,
  output logic [N_PH-1:0] gate_hi_o,
  output logic [N_PH-1:0] gate_lo_o
);
  import pwm_gd_pkg::*;

  pol_e pol;
  logic hi_gate, lo_gate;

  assign pol     = active_low_i ? POL_ACT_LOW : POL_ACT_HIGH;
  assign hi_gate = ~chop_hi_en_i | carrier_i;
  assign lo_gate = ~chop_lo_en_i | carrier_i;

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    logic hi_act, lo_act;
    assign hi_act       = sig_hi_i[p] & hi_gate & ~force_off_i;
    assign lo_act       = sig_lo_i[p] & lo_gate & ~force_off_i;
    assign gate_hi_o[p] = drive_level(hi_act, pol);
    assign gate_lo_o[p] = drive_level(lo_act, pol);
  end
endmodule

// File: rtl/pwm_gate_drive.sv
module pwm_gate_drive #(
  parameter int unsigned N_PH  = 3,
  parameter int unsigned DIV_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PH-1:0]     raw_hi_i,
  input  logic [N_PH-1:0]     raw_lo_i,
  input  logic [N_PH-1:0]     xover_i,
  input  logic [2*N_PH-1:0]   out_en_i,
  input  logic [DIV_W-1:0]    chop_div_i,
  input  logic                chop_hi_en_i,
  input  logic                chop_lo_en_i,
  input  logic                active_low_i,
  input  logic                force_off_i,
  output logic [N_PH-1:0]     gate_hi_o,
  output logic [N_PH-1:0]     gate_lo_o
);
  localparam int unsigned N_PIN = 2 * N_PH;

  logic [N_PH-1:0] sig_hi, sig_lo;
  logic            carrier;

  pwm_steer #(.N_PH(N_PH)) steer_i (
    .raw_hi_i (raw_hi_i),
    .raw_lo_i (raw_lo_i),
    .xover_i  (xover_i),
    .out_en_i (out_en_i),
    .sig_hi_o (sig_hi),
    .sig_lo_o (sig_lo)
  );

  pwm_chop_carrier #(.DIV_W(DIV_W)) carrier_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (chop_div_i),
    .carrier_o (carrier)
  );

  pwm_gate_stage #(.N_PH(N_PH)) stage_i (
    .sig_hi_i     (sig_hi),
    .sig_lo_i     (sig_lo),
    .carrier_i    (carrier),
    .chop_hi_en_i (chop_hi_en_i),
    .chop_lo_en_i (chop_lo_en_i),
    .active_low_i (active_low_i),
    .force_off_i  (force_off_i),
    .gate_hi_o    (gate_hi_o),
    .gate_lo_o    (gate_lo_o)
  );

  AST_FORCE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
                   force_off_i |-> ({gate_lo_o, gate_hi_o} == {N_PIN{active_low_i}}));  // R7
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
                   (!force_off_i && !chop_hi_en_i && !chop_lo_en_i && !active_low_i
                    && xover_i == '0 && out_en_i == '1)
                   |-> (gate_hi_o == raw_hi_i && gate_lo_o == raw_lo_i));             // R1
  AST_HI_CHOP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
                   (chop_hi_en_i && !carrier)
                   |-> (gate_hi_o == {N_PH{active_low_i}}));                           // R3
  AST_LO_CHOP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
                   (chop_lo_en_i && !carrier)
                   |-> (gate_lo_o == {N_PH{active_low_i}}));                           // R4
  AST_EN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
                   (out_en_i == '0) |-> ({gate_lo_o, gate_hi_o} == {N_PIN{active_low_i}})); // R2
endmodule

// File: tb/pwm_gate_drive_tb.sv
module pwm_gate_drive_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] raw_hi_i = '0, raw_lo_i = '0, xover_i = '0;
  logic [5:0] out_en_i = '0;
  logic [7:0] chop_div_i = '0;
  logic       chop_hi_en_i = 1'b0, chop_lo_en_i = 1'b0;
  logic       active_low_i = 1'b0, force_off_i = 1'b0;
  logic [2:0] gate_hi_o, gate_lo_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pwm_gate_drive dut_i (
    .clk_i, .rst_ni, .raw_hi_i, .raw_lo_i, .xover_i, .out_en_i,
    .chop_div_i, .chop_hi_en_i, .chop_lo_en_i, .active_low_i, .force_off_i,
    .gate_hi_o, .gate_lo_o
  );

  // returns {lo[2:0], hi[2:0]}
  function automatic logic [5:0] model(logic [2:0] rh, logic [2:0] rl, logic [2:0] x,
                                       logic [5:0] en, logic pol, logic frc, logic car,
                                       logic chh, logic chl);
    logic [2:0] h, l;
    for (int p = 0; p < 3; p++) begin
      logic sh, sl;
      sh = x[p] ? rl[p] : rh[p];
      sl = x[p] ? rh[p] : rl[p];
      sh = sh & en[2*p];
      sl = sl & en[2*p+1];
      if (chh) sh = sh & car;
      if (chl) sl = sl & car;
      if (frc) begin sh = 1'b0; sl = 1'b0; end
      h[p] = sh ^ pol;
      l[p] = sl ^ pol;
    end
    return {l, h};
  endfunction

  task automatic check(string tag, logic [5:0] exp);
    checks++;
    if ({gate_lo_o, gate_hi_o} !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, {gate_lo_o, gate_hi_o}, exp);
    end
  endtask

  task automatic carrier_run(logic [7:0] div, logic pol, logic chh, logic chl, int n_cyc);
    @(negedge clk_i);
    rst_ni = 1'b0;
    chop_div_i = div; active_low_i = pol; chop_hi_en_i = chh; chop_lo_en_i = chl;
    raw_hi_i = 3'b111; raw_lo_i = 3'b111; xover_i = '0; out_en_i = '1; force_off_i = 0;
    #1;
    check("R5 carrier low in reset", model('1, '1, '0, '1, pol, 0, 0, chh, chl));
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int n = 1; n <= n_cyc; n++) begin
      logic car;
      @(negedge clk_i);
      car = ((n / (int'(div) + 1)) % 2) == 1;
      check("R3 R4 R5 chopped pins", model('1, '1, '0, '1, pol, 0, car, chh, chl));
    end
  endtask

  initial begin
    #1;
    check("R5 reset state", 6'b000000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 R2 R6 full sweep of steering, mask and polarity, chopping off
    for (int pol = 0; pol < 2; pol++)
      for (int x = 0; x < 8; x++)
        for (int en = 0; en < 64; en++)
          for (int r = 0; r < 64; r++) begin
            @(negedge clk_i);
            active_low_i = pol[0]; xover_i = x[2:0]; out_en_i = en[5:0];
            raw_hi_i = r[2:0]; raw_lo_i = r[5:3];
            #1;
            check("R1 R2 R6 steer", model(r[2:0], r[5:3], x[2:0], en[5:0], pol[0], 0, 0, 0, 0));
          end
    // R7 forced off across data, mask and polarity
    force_off_i = 1'b1;
    for (int pol = 0; pol < 2; pol++)
      for (int en = 0; en < 64; en += 7)
        for (int r = 0; r < 64; r++) begin
          @(negedge clk_i);
          active_low_i = pol[0]; out_en_i = en[5:0]; xover_i = r[2:0];
          raw_hi_i = r[2:0]; raw_lo_i = r[5:3]; chop_hi_en_i = r[0]; chop_lo_en_i = r[1];
          #1;
          check("R7 forced off", {6{pol[0]}});
        end
    force_off_i = 1'b0;
    // carrier sweeps, groups independent
    carrier_run(8'd0,   1'b0, 1'b1, 1'b0, 12);
    carrier_run(8'd1,   1'b0, 1'b0, 1'b1, 16);
    carrier_run(8'd2,   1'b1, 1'b1, 1'b1, 20);
    carrier_run(8'd5,   1'b1, 1'b1, 1'b0, 40);
    carrier_run(8'd255, 1'b0, 1'b1, 1'b1, 1100);
    // R7 with chopping running
    @(negedge clk_i);
    force_off_i = 1'b1;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk_i);
      check("R7 forced off while chopping", 6'b000000);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule